// File: doc/BRIEF.md
# Multi-Lane Frame Deskew FIFO

This block collects four byte streams, each arriving in its own write clock domain together with a per-byte frame-start flag. It moves them into one system clock domain. Every lane has its own dual-clock FIFO. Each FIFO entry holds the data byte and the frame-start flag. The write pointer crosses into the system domain as a Gray code through a two-flop synchronizer.

A mode input selects between two behaviours:

- **Aligned mode.** The block lines the lanes up on their frame starts. It throws away whatever sits ahead of each lane's first frame start. It then holds every lane whose frame start has reached the FIFO head. Once all four heads show a frame start, it releases them together. From then on it reads all lanes in lockstep, so matching frame starts leave the block on the same system clock cycle. Skew between lanes of up to ±12 bytes is absorbed. If the lanes cannot be matched, a one-cycle alignment-error pulse is raised and alignment starts over.
- **Independent mode.** Each lane is drained as soon as it holds data. No lane's frame position is related to any other's.

The system clock must run at least as fast as every write clock. Writers have no backpressure.

Top module: `lane_deskew_fifo`

## Requirements
- R1: While reset is asserted and right after its release, `out_valid`, `out_sof` and `align_err` are all zero.
- R2: In independent mode, every entry written to a lane is delivered on that lane, once and in write order, with its frame-start flag. This happens whatever the other lanes are doing. Lane i uses bits [8i+7:8i] of `lane_wdata` and `out_data`, and bit i of every per-lane vector.
- R3: A lane's `out_valid` is asserted only for an entry that was present in that lane's FIFO. A lane that received no writes never shows `out_valid`.
- R4: In aligned mode, entries ahead of a lane's first frame start are dropped. The first entry delivered on each lane is its frame-start entry.
- R5: In aligned mode, `out_valid` is either all ones or all zeros. When it is all ones, the `out_sof` bits are all equal.
- R6: In aligned mode, lanes whose frame starts differ by up to 24 bytes between the earliest and the latest lane (±12 around the centre) are aligned without `align_err`.
- R7: Once aligned, every later entry of every lane is delivered exactly once and in order.
- R8: While a lane is held on a frame start, the alarm fires if that lane's FIFO fill, as seen in the system domain, exceeds 24 entries (the start plus 24 behind it). `align_err` then pulses for one cycle, all held frame starts are dropped, and alignment restarts. A later matched set of frame starts aligns normally.
- R9: Once aligned, the alarm also fires if the lane heads being read together disagree on the frame-start flag. `align_err` pulses and the lanes realign on their next frame starts.
- R10: `align_err` stays low in independent mode.
- R11: With writes no faster than the system clock and skew within R6, no lane FIFO fill exceeds its depth of 32 entries, so no entry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lane_clk | input | 4 | Write clock of each lane |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| lane_wen | input | 4 | Per-lane write strobe, sampled on that lane's clock |
| lane_wdata | input | 32 | Per-lane write byte |
| lane_wsof | input | 4 | Per-lane frame-start flag for the written byte |
| sys_clk | input | 1 | System clock for reading and outputs |
| mode_indep | input | 1 | 1 = independent lanes, 0 = aligned lanes |
| out_data | output | 32 | Per-lane output byte (held when not valid) |
| out_sof | output | 4 | Per-lane frame-start flag of the output byte |
| out_valid | output | 4 | Per-lane output byte valid |
| align_err | output | 1 | One-cycle alignment-failure pulse |

## Verification
The hardest state to reach from the ports is a lane-head disagreement after lock (R9). By construction, the lanes are read in lockstep. The bench gets there by adding one extra filler byte in the middle of the first frame on a single lane. The lanes are already locked by then, and the next frame start on that lane lands one position late.

The fill-level alarm (R8) is reached by giving one lane no frame start at all while the others hold theirs. A matched set of streams is then sent without a reset, to show that alignment recovers.

Skew cases come from a table of per-lane lead-in lengths. The lane clocks run at slightly different rates, so the skew seen at the FIFO heads drifts, as it would between real cards.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

    // Alignment controller state
    typedef enum logic {
        ST_SEEK = 1'b0,
        ST_RUN  = 1'b1
    } align_st_e;

endpackage

// File: rtl/ptr_sync2.sv
module ptr_sync2 #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.s2;

endmodule

// File: rtl/lane_cdc_fifo.sv
module lane_cdc_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sof,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head_data,
    output logic              head_sof,
    output logic              empty,
    output logic [ADDR_W:0]   level
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wptr_t;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
    } rptr_t;

    function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        for (int i = 0; i < PTR_W; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    logic [DATA_W:0]  mem [DEPTH];
    wptr_t            w_d, w_q;
    rptr_t            r_d, r_q;
    logic [PTR_W-1:0] wgray_sys;
    logic [PTR_W-1:0] wbin_sys;
    logic [DATA_W:0]  head;

    // Write domain
    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[w_q.bin[ADDR_W-1:0]] <= {wr_sof, wr_data};
    end

    // Crossing of the write pointer
    ptr_sync2 #(.W(PTR_W)) u_wsync (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (w_q.gray),
        .q     (wgray_sys)
    );

    assign wbin_sys = gray_to_bin(wgray_sys);

    // Read domain
    always_comb begin
        r_d = r_q;
        if (rd_en) r_d.bin = r_q.bin + 1'b1;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head      = mem[r_q.bin[ADDR_W-1:0]];
    assign head_data = head[DATA_W-1:0];
    assign head_sof  = head[DATA_W];
    assign empty     = (wbin_sys == r_q.bin);
    assign level     = wbin_sys - r_q.bin;

endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import lane_deskew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int ADDR_W   = 5,
    parameter int ERR_FILL = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_indep,
    input  logic [LANES-1:0]             empty,
    input  logic [LANES-1:0]             head_sof,
    input  logic [LANES-1:0][ADDR_W:0]   level,
    output logic [LANES-1:0]             rd_en,
    output logic [LANES-1:0]             emit,
    output logic                         err
);

    localparam logic [ADDR_W:0] FILL_LIM = (ADDR_W+1)'(ERR_FILL);

    typedef struct packed {
        align_st_e st;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic [LANES-1:0] ready;
    logic [LANES-1:0] at_sync;
    logic [LANES-1:0] overfill;

    always_comb begin
        ready   = ~empty;
        at_sync = ready & head_sof;
        for (int i = 0; i < LANES; i++) begin
            overfill[i] = at_sync[i] && (level[i] > FILL_LIM);
        end
    end

    always_comb begin
        c_d   = c_q;
        rd_en = '0;
        emit  = '0;
        err   = 1'b0;
        if (mode_indep) begin
            rd_en  = ready;
            emit   = ready;
            c_d.st = ST_SEEK;
        end else begin
            unique case (c_q.st)
                ST_SEEK: begin
                    if (&at_sync) begin
                        rd_en  = '1;
                        emit   = '1;
                        c_d.st = ST_RUN;
                    end else if (|overfill) begin
                        err   = 1'b1;
                        rd_en = at_sync;
                    end else begin
                        rd_en = ready & ~head_sof;
                    end
                end
                ST_RUN: begin
                    if (&ready) begin
                        if ((head_sof != '0) && (head_sof != '1)) begin
                            err    = 1'b1;
                            c_d.st = ST_SEEK;
                        end else begin
                            rd_en = '1;
                            emit  = '1;
                        end
                    end
                end
                default: c_d.st = ST_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_SEEK};
        else        c_q <= c_d;
    end

endmodule

// File: rtl/lane_deskew_fifo.sv
module lane_deskew_fifo #(
    parameter int LANES    = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int MAX_SKEW = 12
) (
    input  logic [LANES-1:0]        lane_clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_wen,
    input  logic [LANES*DATA_W-1:0] lane_wdata,
    input  logic [LANES-1:0]        lane_wsof,
    input  logic                    sys_clk,
    input  logic                    mode_indep,
    output logic [LANES*DATA_W-1:0] out_data,
    output logic [LANES-1:0]        out_sof,
    output logic [LANES-1:0]        out_valid,
    output logic                    align_err
);

    localparam int ERR_FILL = 2 * MAX_SKEW;

    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] data;
        logic [LANES-1:0]             sof;
        logic [LANES-1:0]             valid;
        logic                         err;
    } out_t;

    logic [LANES-1:0][DATA_W-1:0] head_data;
    logic [LANES-1:0]             head_sof;
    logic [LANES-1:0]             lane_empty;
    logic [LANES-1:0][ADDR_W:0]   lane_level;
    logic [LANES-1:0]             lane_rd;
    logic [LANES-1:0]             lane_emit;
    logic                         err_pulse;
    out_t                         o_d, o_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_cdc_fifo #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_fifo (
            .wr_clk    (lane_clk[g]),
            .rst_n     (rst_n),
            .wr_en     (lane_wen[g]),
            .wr_data   (lane_wdata[g*DATA_W +: DATA_W]),
            .wr_sof    (lane_wsof[g]),
            .rd_clk    (sys_clk),
            .rd_en     (lane_rd[g]),
            .head_data (head_data[g]),
            .head_sof  (head_sof[g]),
            .empty     (lane_empty[g]),
            .level     (lane_level[g])
        );
    end

    deskew_ctrl #(
        .LANES    (LANES),
        .ADDR_W   (ADDR_W),
        .ERR_FILL (ERR_FILL)
    ) u_ctrl (
        .clk        (sys_clk),
        .rst_n      (rst_n),
        .mode_indep (mode_indep),
        .empty      (lane_empty),
        .head_sof   (head_sof),
        .level      (lane_level),
        .rd_en      (lane_rd),
        .emit       (lane_emit),
        .err        (err_pulse)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = lane_emit;
        o_d.err   = err_pulse;
        for (int i = 0; i < LANES; i++) begin
            o_d.sof[i] = lane_emit[i] & head_sof[i];
            if (lane_emit[i]) o_d.data[i] = head_data[i];
        end
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_data  = o_q.data;
    assign out_sof   = o_q.sof;
    assign out_valid = o_q.valid;
    assign align_err = o_q.err;

endmodule

// File: rtl/deskew_chk.sv
module deskew_chk #(
    parameter int LANES  = 4,
    parameter int ADDR_W = 5
) (
    input logic                       sys_clk,
    input logic                       rst_n,
    input logic                       mode_indep,
    input logic [LANES-1:0]           out_valid,
    input logic [LANES-1:0]           out_sof,
    input logic                       align_err,
    input logic [LANES-1:0]           lane_empty,
    input logic [LANES-1:0][ADDR_W:0] lane_level
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_l
        // R3
        valid_needs_data_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
            out_valid[i] |-> $past(!lane_empty[i]));

        // R11
        no_overflow_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
            lane_level[i] <= (ADDR_W+1)'(DEPTH));
    end

    // R5
    lockstep_out_chk: assert property (@(posedge sys_clk) disable iff (!rst_n || mode_indep)
        (out_valid != '0) |-> ((out_valid == '1) && ((out_sof == '0) || (out_sof == '1))));

    // R10
    no_err_indep_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (mode_indep && $past(mode_indep)) |-> !align_err);

endmodule

bind lane_deskew_fifo deskew_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_chk (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .mode_indep (mode_indep),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .align_err  (align_err),
    .lane_empty (lane_empty),
    .lane_level (lane_level)
);

// File: tb/lane_deskew_fifo_bench.sv
`timescale 1ns/1ps
module lane_deskew_fifo_bench;

    localparam int FRM    = 40;
    localparam int GOTMAX = 128;
    localparam logic [7:0] FILL = 8'hEE;
    // per vector: lead-in length of lanes 0..3, expected align_err pulses
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{0, 0, 0, 0, 0},
        '{12, 0, 0, 0, 0},
        '{0, 6, 12, 3, 0},
        '{20, 10, 0, 5, 0},
        '{1, 2, 3, 4, 0},
        '{0, 20, 20, 0, 0}
    };

    logic        sys_clk = 0;
    logic        c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    logic        rst_n = 0;
    logic        mode_indep = 0;
    logic [7:0]  wd [4];
    logic        ws [4];
    logic        we [4];
    logic [31:0] out_data;
    logic [3:0]  out_sof, out_valid;
    logic        align_err;

    logic        mon_clr = 1;
    logic [7:0]  got_d [4][GOTMAX];
    logic        got_s [4][GOTMAX];
    int          got_n [4];
    int          lockfail, err_cnt;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #10 sys_clk = ~sys_clk;
    always #10.5  c0 = ~c0;
    always #10.65 c1 = ~c1;
    always #10.8  c2 = ~c2;
    always #10.95 c3 = ~c3;

    lane_deskew_fifo u_lane_deskew_fifo (
        .lane_clk   ({c3, c2, c1, c0}),
        .rst_n      (rst_n),
        .lane_wen   ({we[3], we[2], we[1], we[0]}),
        .lane_wdata ({wd[3], wd[2], wd[1], wd[0]}),
        .lane_wsof  ({ws[3], ws[2], ws[1], ws[0]}),
        .sys_clk    (sys_clk),
        .mode_indep (mode_indep),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_valid  (out_valid),
        .align_err  (align_err)
    );

    function automatic logic [7:0] fbyte(input int l, input int j);
        return {l[1:0], j[5:0]};
    endfunction

    always @(negedge sys_clk) begin
        if (mon_clr) begin
            for (int l = 0; l < 4; l++) got_n[l] = 0;
            lockfail = 0;
            err_cnt  = 0;
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (out_valid[l]) begin
                    if (got_n[l] < GOTMAX) begin
                        got_d[l][got_n[l]] = out_data[l*8 +: 8];
                        got_s[l][got_n[l]] = out_sof[l];
                    end
                    got_n[l]++;
                end
            end
            if (!mode_indep && out_valid != 4'h0 &&
                (out_valid != 4'hF || (out_sof != 4'h0 && out_sof != 4'hF)))
                lockfail++;
            if (align_err) err_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic lane_edge(input int l);
        case (l)
            0: @(posedge c0);
            1: @(posedge c1);
            2: @(posedge c2);
            default: @(posedge c3);
        endcase
        #1;
    endtask

    task automatic push(input int l, input logic [7:0] d, input logic s);
        lane_edge(l);
        wd[l] = d;
        ws[l] = s;
        we[l] = 1'b1;
    endtask

    // lead-in fillers, then frames; extra_at inserts one filler at that frame position
    task automatic drive_lane(input int l, input int pre, input int nfr,
                              input int extra_at, input bit with_sync);
        for (int k = 0; k < pre; k++) push(l, FILL, 1'b0);
        for (int f = 0; f < nfr; f++) begin
            for (int j = 0; j < FRM; j++) begin
                if (extra_at == f*FRM + j) push(l, FILL, 1'b0);
                push(l, fbyte(l, j), with_sync && (j == 0));
            end
        end
        lane_edge(l);
        we[l] = 1'b0;
    endtask

    task automatic do_reset(input bit indep);
        rst_n = 0;
        mon_clr = 1;
        mode_indep = indep;
        repeat (3) @(posedge sys_clk);
        #3;
        // R1: reset values
        check(out_valid == 0 && out_sof == 0 && align_err == 0, "R1 reset outputs",
              {out_valid, out_sof, 3'b0, align_err}, 0);
        @(negedge sys_clk);
        rst_n = 1;
        #2 mon_clr = 0;
        repeat (2) @(posedge sys_clk);
        #3;
        check(out_valid == 0 && align_err == 0, "R1 after release",
              {out_valid, 3'b0, align_err}, 0);
    endtask

    task automatic run_lanes(input int p0, input int p1, input int p2, input int p3,
                             input logic [3:0] act, input int nfr,
                             input int extra3, input bit sync3);
        fork
            begin if (act[0]) drive_lane(0, p0, nfr, -1, 1'b1); end
            begin if (act[1]) drive_lane(1, p1, nfr, -1, 1'b1); end
            begin if (act[2]) drive_lane(2, p2, nfr, -1, 1'b1); end
            begin if (act[3]) drive_lane(3, p3, nfr, extra3, sync3); end
        join
        repeat (150) @(posedge sys_clk);
    endtask

    // count mismatches of lane l against lead-in pre and nfr frames
    function automatic int seq_err(input int l, input int pre, input int n);
        int e = 0;
        for (int k = 0; k < n && k < GOTMAX; k++) begin
            logic [7:0] xd;
            logic       xs;
            if (k < pre) begin
                xd = FILL;
                xs = 1'b0;
            end else begin
                xd = fbyte(l, (k - pre) % FRM);
                xs = ((k - pre) % FRM) == 0;
            end
            if (got_d[l][k] !== xd || got_s[l][k] !== xs) e++;
        end
        return e;
    endfunction

    initial begin
        for (int l = 0; l < 4; l++) begin
            wd[l] = 0;
            ws[l] = 0;
            we[l] = 0;
        end

        // vector table, aligned mode
        for (int v = 0; v < NVEC; v++) begin
            do_reset(1'b0);
            run_lanes(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 4'hF, 2, -1, 1'b1);
            for (int l = 0; l < 4; l++) begin
                // R7: all entries after lock delivered
                check(got_n[l] == 2*FRM, "R7 lane count", got_n[l], 2*FRM);
                // R4: first delivered entry is the frame start
                check(got_s[l][0] === 1'b1 && got_d[l][0] === fbyte(l, 0),
                      "R4 first entry", got_d[l][0], fbyte(l, 0));
                // R7 R11: order intact, nothing lost
                check(seq_err(l, 0, got_n[l]) == 0, "R7 R11 sequence",
                      seq_err(l, 0, got_n[l]), 0);
            end
            check(lockfail == 0, "R5 lockstep", lockfail, 0);
            check(err_cnt == VEC[v][4], "R6 skew tolerated", err_cnt, VEC[v][4]);
        end

        // independent mode, single lane
        do_reset(1'b1);
        run_lanes(0, 0, 0, 0, 4'b0010, 1, -1, 1'b1);
        check(got_n[1] == FRM, "R2 single lane count", got_n[1], FRM);
        check(seq_err(1, 0, got_n[1]) == 0, "R2 single lane data", seq_err(1, 0, got_n[1]), 0);
        check(got_n[0] == 0 && got_n[2] == 0 && got_n[3] == 0, "R3 idle lanes silent",
              got_n[0] + got_n[2] + got_n[3], 0);
        check(err_cnt == 0, "R10 no error single", err_cnt, 0);

        // independent mode, lanes wholly misaligned
        do_reset(1'b1);
        run_lanes(0, 15, 30, 5, 4'hF, 2, -1, 1'b1);
        begin
            int pre [4] = '{0, 15, 30, 5};
            for (int l = 0; l < 4; l++) begin
                check(got_n[l] == pre[l] + 2*FRM, "R2 lane count", got_n[l], pre[l] + 2*FRM);
                check(seq_err(l, pre[l], got_n[l]) == 0, "R2 lane data",
                      seq_err(l, pre[l], got_n[l]), 0);
            end
        end
        check(err_cnt == 0, "R10 no error misaligned", err_cnt, 0);

        // aligned mode, lane 3 never shows a frame start
        do_reset(1'b0);
        run_lanes(0, 0, 0, 0, 4'hF, 1, -1, 1'b0);
        check(err_cnt >= 1, "R8 fill alarm", err_cnt, 1);
        check(got_n[0] + got_n[1] + got_n[2] + got_n[3] == 0, "R8 nothing delivered",
              got_n[0] + got_n[1] + got_n[2] + got_n[3], 0);
        // restart without reset
        run_lanes(0, 3, 0, 3, 4'hF, 2, -1, 1'b1);
        for (int l = 0; l < 4; l++) begin
            check(got_n[l] == 2*FRM && seq_err(l, 0, got_n[l]) == 0, "R8 relock",
                  got_n[l], 2*FRM);
        end

        // aligned mode, lane 3 slips by one byte after lock
        do_reset(1'b0);
        run_lanes(0, 0, 0, 0, 4'hF, 2, 20, 1'b1);
        check(err_cnt == 1, "R9 mismatch alarm", err_cnt, 1);
        check(lockfail == 0, "R9 R5 lockstep", lockfail, 0);
        for (int l = 0; l < 4; l++) begin
            check(got_n[l] == 2*FRM, "R9 lane count", got_n[l], 2*FRM);
            check(got_s[l][0] === 1'b1 && got_s[l][FRM] === 1'b1, "R9 realigned start",
                  {got_s[l][0], got_s[l][FRM]}, 3);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule